// File: doc/BRIEF.md
# Oscillation-Detect Trim Calibration Controller

This block is the digital half of a closed-loop stability trim for a self-biased ring amplifier. A trim code drives an external programmable resistor that widens the amplifier's dead zone. A comparator outside the block judges the amplifier's common-mode feedback node once per amplification phase, and each judgement reaches the block as one decision bit, qualified by a sample strobe. The block starts at the lowest trim and collects a window of decisions. If they do not all agree, it treats the amplifier as oscillating, flags it and moves the trim one step higher. If they do all agree, it adds one extra step as headroom and stops.

A pulse on the start input begins a run. While the run lasts, the busy output is high. When the amplifier settles, the done output rises and stays high until the next start. The agreement test is kept as a running comparison against the first decision of the window, so the window needs no sample memory.

Top module: `oscal_top`

## Requirements
- R1: After reset, trimCode is 0, and calBusy, calDone, oscPulse and rangeExhausted are all low.
- R2: A calStart high at a clock edge while calBusy is low sets trimCode to 0, clears rangeExhausted and calDone, raises calBusy and empties the window. All of these are visible after that edge.
- R3: Only while calBusy is high does each clock edge with sampleStrobe high capture cmpDecision as one decision. Strobes while the block is idle or done have no effect on any output or on the next window.
- R4: A window holds exactly 16 decisions. Its verdict takes effect at the edge that captures the 16th decision, and the next window begins empty.
- R5: If all 16 decisions are equal (all 0 or all 1), the verdict is stable. trimCode rises by one margin step, calBusy falls and calDone rises.
- R6: If any decision in a window differs from the others, oscPulse is high for exactly the one cycle after the verdict edge, trimCode rises by one, and calBusy stays high.
- R7: trimCode is 4 bits wide, with 0 as the smallest and 15 as the largest resistance. It changes only at a start or at a window verdict.
- R8: A step requested while trimCode is 15 leaves it at 15 and sets rangeExhausted, which holds until the next start.
- R9: calDone holds until a start. A calStart while calBusy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calStart | input | 1 | Begin a calibration run (ignored while busy) |
| sampleStrobe | input | 1 | One comparator decision is valid this cycle |
| cmpDecision | input | 1 | Comparator decision bit |
| trimCode | output | 4 | Resistor trim code, 0 = smallest resistance |
| oscPulse | output | 1 | One-cycle flag for a window that disagreed |
| calBusy | output | 1 | Calibration in progress |
| calDone | output | 1 | Calibration settled, held until next start |
| rangeExhausted | output | 1 | A step was requested at the top code |

## Verification
Every result of this block is registered once. A start, or the capture of the 16th decision, shows on trimCode, calBusy, calDone, oscPulse and rangeExhausted one clock edge later. The bench drives inputs on the falling edge and advances its own reference model for the edge that follows. It then compares all five outputs at the next falling edge, half a period after they were due. The bench checks oscPulse in every cycle, so a pulse that lasts too long, or that comes one cycle early or late, is caught as a mismatch.

// File: rtl/oscal_pkg.sv
package oscal_pkg;
  typedef struct packed {
    logic clrAll;
    logic capture;
    logic bump;
  } calStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } calState_t;
endpackage

// File: rtl/oscal_datapath.sv
module oscal_datapath
  import oscal_pkg::*;
#(
  parameter int SAMPLE_N = 16,
  parameter int TRIM_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       ctrl,
  input  logic              cmpDecision,
  output logic              lastSlot,
  output logic              mismatchNow,
  output logic [TRIM_W-1:0] trimCode,
  output logic              rangeExhausted
);
  localparam int CNT_W = (SAMPLE_N > 1) ? $clog2(SAMPLE_N) : 1;
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(SAMPLE_N - 1);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  logic [CNT_W-1:0] sampleCount;
  logic             firstBit;
  logic             mismatch;
  logic             atMax;

  assign lastSlot    = (sampleCount == LAST_IDX);
  assign mismatchNow = mismatch | ((sampleCount != '0) & (cmpDecision != firstBit));
  assign atMax       = (trimCode == TRIM_MAX);

  // window tracking: counter, reference bit, sticky disagreement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCount <= '0;
      firstBit    <= 1'b0;
      mismatch    <= 1'b0;
    end else if (ctrl.clrAll) begin
      sampleCount <= '0;
      firstBit    <= 1'b0;
      mismatch    <= 1'b0;
    end else if (ctrl.capture) begin
      if (lastSlot) begin
        sampleCount <= '0;
        mismatch    <= 1'b0;
      end else begin
        sampleCount <= sampleCount + CNT_W'(1);
        mismatch    <= mismatchNow;
        if (sampleCount == '0) firstBit <= cmpDecision;
      end
    end
  end

  // trim register with saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trimCode       <= '0;
      rangeExhausted <= 1'b0;
    end else if (ctrl.clrAll) begin
      trimCode       <= '0;
      rangeExhausted <= 1'b0;
    end else if (ctrl.bump) begin
      if (atMax) rangeExhausted <= 1'b1;
      else       trimCode       <= trimCode + TRIM_W'(1);
    end
  end

  // R7: trim moves only on a start or a verdict step
  a_r7_trim_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.bump && !ctrl.clrAll) |=> $stable(trimCode));

  // R6: a verdict step below the top raises the code by exactly one
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.bump && !ctrl.clrAll && !atMax) |=> (trimCode == $past(trimCode) + TRIM_W'(1)));

  // R8: a step at the top holds the code and flags exhaustion
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.bump && !ctrl.clrAll && atMax) |=> (trimCode == TRIM_MAX && rangeExhausted));

  // R8: exhaustion flag sticks until a start
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rangeExhausted && !ctrl.clrAll) |=> rangeExhausted);
endmodule

// File: rtl/oscal_control.sv
module oscal_control
  import oscal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        calStart,
  input  logic        sampleStrobe,
  input  logic        lastSlot,
  input  logic        mismatchNow,
  output calStrobes_t ctrl,
  output logic        oscPulse,
  output logic        calBusy,
  output logic        calDone
);
  calState_t state, stateNext;
  logic verdict;

  assign calBusy = (state == ST_RUN);
  assign calDone = (state == ST_DONE);
  assign verdict = calBusy & sampleStrobe & lastSlot;

  always_comb begin
    ctrl         = '0;
    stateNext    = state;
    ctrl.capture = calBusy & sampleStrobe;
    ctrl.bump    = verdict;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (calStart) begin
          ctrl.clrAll = 1'b1;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (verdict && !mismatchNow) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      oscPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      oscPulse <= verdict & mismatchNow;
    end
  end

  // R6: oscillation flag never lasts two cycles
  a_r6_osc_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    oscPulse |=> !oscPulse);

  // R9: done holds until a start arrives
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !calStart) |=> calDone);

  // R9: a start during a run does not disturb it
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && !(sampleStrobe && lastSlot)) |=> calBusy);

  // R6: oscillation flag only while still running
  a_r6_osc_busy: assert property (@(posedge clk) disable iff (!rstN)
    oscPulse |-> calBusy);
endmodule

// File: rtl/oscal_top.sv
module oscal_top
  import oscal_pkg::*;
#(
  parameter int SAMPLE_N = 16,
  parameter int TRIM_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calStart,
  input  logic              sampleStrobe,
  input  logic              cmpDecision,
  output logic [TRIM_W-1:0] trimCode,
  output logic              oscPulse,
  output logic              calBusy,
  output logic              calDone,
  output logic              rangeExhausted
);
  calStrobes_t ctrl;
  logic lastSlot;
  logic mismatchNow;

  oscal_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .calStart     (calStart),
    .sampleStrobe (sampleStrobe),
    .lastSlot     (lastSlot),
    .mismatchNow  (mismatchNow),
    .ctrl         (ctrl),
    .oscPulse     (oscPulse),
    .calBusy      (calBusy),
    .calDone      (calDone)
  );

  oscal_datapath #(
    .SAMPLE_N (SAMPLE_N),
    .TRIM_W   (TRIM_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctrl           (ctrl),
    .cmpDecision    (cmpDecision),
    .lastSlot       (lastSlot),
    .mismatchNow    (mismatchNow),
    .trimCode       (trimCode),
    .rangeExhausted (rangeExhausted)
  );

  // R5: done and busy are never high together
  a_r5_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(calBusy && calDone));
endmodule

// File: tb/sim_oscal_top.sv
`timescale 1ns/1ps
module sim_oscal_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       calStart = 1'b0;
  logic       sampleStrobe = 1'b0;
  logic       cmpDecision = 1'b0;
  logic [3:0] trimCode;
  logic       oscPulse, calBusy, calDone, rangeExhausted;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  int  mTrim = 0, mCnt = 0;
  bit  mBusy = 0, mDone = 0, mExh = 0, mFirst = 0, mMis = 0, mOsc = 0;
  int  seed = 32'h5eed_0a1c;

  oscal_top u0 (
    .clk(clk), .rstN(rstN), .calStart(calStart), .sampleStrobe(sampleStrobe),
    .cmpDecision(cmpDecision), .trimCode(trimCode), .oscPulse(oscPulse),
    .calBusy(calBusy), .calDone(calDone), .rangeExhausted(rangeExhausted)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bumped(input int t);
    return (t == 15) ? 15 : t + 1;
  endfunction

  // advance reference model for one clock edge
  task automatic modelStep(input bit st, input bit sb, input bit d);
    mOsc = 0;
    if (!mBusy) begin
      if (st) begin
        mTrim = 0; mBusy = 1; mDone = 0; mExh = 0; mCnt = 0; mMis = 0;
      end
    end else if (sb) begin
      if (mCnt == 0) mFirst = d;
      else if (d != mFirst) mMis = 1;
      if (mCnt == 15) begin
        if (mTrim == 15) mExh = 1;
        mTrim = bumped(mTrim);
        if (mMis) mOsc = 1;
        else begin mBusy = 0; mDone = 1; end
        mCnt = 0; mMis = 0;
      end else mCnt++;
    end
  endtask

  task automatic compareAll();
    check("R7 trimCode", trimCode, mTrim);
    check("R6 oscPulse", oscPulse, mOsc);
    check("R2 calBusy", calBusy, mBusy);
    check("R5 calDone", calDone, mDone);
    check("R8 rangeExhausted", rangeExhausted, mExh);
  endtask

  // called at a falling edge: drive, step model, wait one edge, compare
  task automatic tick(input bit st, input bit sb, input bit d);
    calStart = st; sampleStrobe = sb; cmpDecision = d;
    modelStep(st, sb, d);
    @(posedge clk);
    @(negedge clk);
    calStart = 0; sampleStrobe = 0;
    compareAll();
  endtask

  // one full window; flipAt < 0 means all equal
  task automatic window(input bit level, input int flipAt);
    for (int i = 0; i < 16; i++) tick(1'b0, 1'b1, (i == flipAt) ? ~level : level);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 trim", trimCode, 0);
    check("R1 busy", calBusy, 0);
    check("R1 done", calDone, 0);
    check("R1 osc", oscPulse, 0);
    check("R1 exh", rangeExhausted, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: strobes while idle are ignored
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b1, i[0]);
    // R2: start
    tick(1'b1, 1'b0, 1'b0);
    check("R2 busy after start", calBusy, 1);
    // R3: idle-cycle gaps between strobes; R4 mismatch on last sample
    for (int i = 0; i < 16; i++) begin
      tick(1'b0, 1'b0, 1'b1);
      tick(1'b0, 1'b1, (i == 15));
    end
    check("R6 trim after osc window", trimCode, 1);
    // R9: start during busy ignored; R6 mismatch on first sample
    tick(1'b1, 1'b0, 1'b0);
    window(1'b1, 0);
    // R5: stable all-ones window, margin step
    window(1'b1, -1);
    check("R5 done after stable", calDone, 1);
    check("R5 trim margin", trimCode, 3);
    // R9: done holds with strobes and no start
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, i[1]);
    check("R9 done held", calDone, 1);
    // R2: restart, R5 stable all-zeros window
    tick(1'b1, 1'b0, 1'b0);
    check("R2 trim cleared", trimCode, 0);
    window(1'b0, -1);
    check("R5 zeros stable trim", trimCode, 1);
    // R8: saturate with 17 oscillating windows
    tick(1'b1, 1'b0, 1'b0);
    for (int w = 0; w < 17; w++) window(w[0], w % 16);
    check("R8 trim at max", trimCode, 15);
    check("R8 exhausted", rangeExhausted, 1);
    window(1'b0, -1);
    check("R8 margin held at max", trimCode, 15);
    check("R5 done at max", calDone, 1);
    tick(1'b1, 1'b0, 1'b0);
    check("R8 flag cleared by start", rangeExhausted, 0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      bit lvl;
      r = $urandom(seed) % 1000;
      seed = seed + 1;
      lvl = ((n / 64) % 2) == 1;
      tick(($urandom % 40) == 0, ($urandom % 3) != 0,
           (($urandom % 24) == 0) ? ~lvl : lvl);
      if (r == 0) begin
        // occasional forced stable stretch
        for (int k = 0; k < 16; k++) tick(1'b0, 1'b1, lvl);
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule